// File: doc/BRIEF.md
# Predicate Register File with Compare Write

This block holds a file of one-bit predicate registers for predicated execution. Compare operations write the file. Each compare names two target predicates and carries the outcome of an equality test made elsewhere. The first target takes the outcome and the second target takes its inverse, so the two halves of an if/else can each carry their own guard and no branch is needed.

On the read side, an issuing instruction presents the index of its qualifying predicate. One cycle later the block answers with a registered decision: commit the instruction's result, or squash it. Predicate 0 always reads as 1, so an instruction that is not really predicated names predicate 0 and always commits.

The file takes several compare writes per cycle (two by default). Software must put a stop between a compare and any instruction that consumes its predicate. The block therefore provides no same-cycle forwarding: a predicate written at one clock edge is seen by reads from the next cycle onwards.

Top module: `pred_file`

## Requirements
- R1: The file holds 64 predicates of one bit each, addressed by a 6-bit index. Every index from 1 to 63 can be written and read back independently.
- R2: A synchronous active-high reset clears predicates 1 to 63 to 0. In the cycle after reset, with no read requested, `commit_o` and `squash_o` are both 0.
- R3: Predicate 0 always reads as 1. A compare that names index 0 as either target leaves it unchanged, and the other target of that compare is still written.
- R4: A valid compare on any port writes its first target (`cmp_tidx_i`) with `cmp_cond_i` and its second target (`cmp_fidx_i`) with the inverse of `cmp_cond_i`.
- R5: A read request (`rd_vld_i`=1) whose predicate is 1 gives `commit_o`=1 and `squash_o`=0 in the cycle after the request.
- R6: A read request whose predicate is 0 gives `commit_o`=0 and `squash_o`=1 in the cycle after the request.
- R7: In the cycle after a cycle with `rd_vld_i`=0, `commit_o` and `squash_o` are both 0.
- R8: There is no bypass. A read in the same cycle as a compare write returns the value from before that write, and a read in the next cycle returns the new value.
- R9: If one compare names the same index as both targets, that predicate takes the first-target value (`cmp_cond_i`).
- R10: If two ports write the same predicate in one cycle, the higher-numbered port wins. With the default of two ports, port 1 (the upper field of each packed bus) overrides port 0.
- R11: Compares on different ports that touch different predicates in the same cycle all take effect.
- R12: A port whose `cmp_vld_i` bit is 0 changes no predicate, whatever its index and condition inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_vld_i | input | 2 | Compare valid, one bit per port |
| cmp_tidx_i | input | 12 | First-target index per port; port p occupies bits [6p+5:6p] |
| cmp_fidx_i | input | 12 | Second-target index per port, packed the same way |
| cmp_cond_i | input | 2 | Equality test outcome per port |
| rd_vld_i | input | 1 | Read request for a qualifying predicate |
| rd_idx_i | input | 6 | Index of the qualifying predicate |
| commit_o | output | 1 | Registered: commit the instruction's result |
| squash_o | output | 1 | Registered: discard the instruction's result |

## Verification
Compares take effect at the clock edge that samples them. The commit or squash decision is registered, so it appears one edge after the read request. A read therefore shows a compare's effect no sooner than one cycle after the compare, and the decision is available one further edge later. The bench drives every input one time unit after a rising edge. It samples outputs one time unit after the following rising edge, which is exactly where a read presented in the previous cycle is due. The no-bypass case puts a compare and a read of the same target in one cycle, expects the old value, and then expects the new value on the next read.

// File: rtl/pred_pkg.sv
package pred_pkg;

  localparam int unsigned PRED_NUM_DEF = 64;
  localparam int unsigned CMP_PORTS_DEF = 2;

  // outcome of a qualifying-predicate lookup
  typedef enum logic [1:0] {
    RD_IDLE   = 2'b00,
    RD_COMMIT = 2'b01,
    RD_SQUASH = 2'b10
  } rd_outcome_e;

  function automatic rd_outcome_e decide(input logic vld, input logic pred);
    if (!vld)     return RD_IDLE;
    else if (pred) return RD_COMMIT;
    else          return RD_SQUASH;
  endfunction

endpackage

// File: rtl/pred_cmp_decode.sv
module pred_cmp_decode #(
  parameter int unsigned NPRED = 64,
  localparam int unsigned IW = $clog2(NPRED)
) (
  input  logic              vld,
  input  logic [IW-1:0]     tidx,
  input  logic [IW-1:0]     fidx,
  input  logic              cond,
  output logic [NPRED-1:0]  we,
  output logic [NPRED-1:0]  wval
);

  // one-hot decode of both targets; first target takes precedence on a tie
  for (genvar k = 0; k < NPRED; k++) begin : g_dec
    logic hit_t;
    logic hit_f;
    assign hit_t   = (tidx == IW'(k));
    assign hit_f   = (fidx == IW'(k));
    assign we[k]   = vld & (hit_t | hit_f);
    assign wval[k] = hit_t ? cond : ~cond;
  end

endmodule

// File: rtl/pred_bank.sv
module pred_bank #(
  parameter int unsigned NPRED = 64,
  parameter int unsigned NCMP  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCMP*NPRED-1:0] we_all,
  input  logic [NCMP*NPRED-1:0] wval_all,
  output logic [NPRED-1:0]      state
);

  // entry 0 is a constant true; others are individually reset flops
  assign state[0] = 1'b1;

  for (genvar k = 1; k < NPRED; k++) begin : g_bit
    logic en;
    logic nxt;
    logic q;

    // later ports override earlier ones
    always_comb begin
      en  = 1'b0;
      nxt = q;
      for (int p = 0; p < int'(NCMP); p++) begin
        if (we_all[p*NPRED + k]) begin
          en  = 1'b1;
          nxt = wval_all[p*NPRED + k];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)     q <= 1'b0;
      else if (en) q <= nxt;
    end

    assign state[k] = q;
  end

endmodule

// File: rtl/pred_rd_port.sv
module pred_rd_port
  import pred_pkg::*;
#(
  parameter int unsigned NPRED = 64,
  localparam int unsigned IW = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_vld,
  input  logic [IW-1:0]    rd_idx,
  input  logic [NPRED-1:0] state,
  output logic             commit,
  output logic             squash
);

  rd_outcome_e outc_q;
  logic        sel;

  assign sel = state[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) outc_q <= RD_IDLE;
    else     outc_q <= decide(rd_vld, sel);
  end

  assign commit = (outc_q == RD_COMMIT);
  assign squash = (outc_q == RD_SQUASH);

endmodule

// File: rtl/pred_file.sv
module pred_file
  import pred_pkg::*;
#(
  parameter int unsigned NPRED = PRED_NUM_DEF,
  parameter int unsigned NCMP  = CMP_PORTS_DEF,
  localparam int unsigned IW = $clog2(NPRED)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCMP-1:0]    cmp_vld_i,
  input  logic [NCMP*IW-1:0] cmp_tidx_i,
  input  logic [NCMP*IW-1:0] cmp_fidx_i,
  input  logic [NCMP-1:0]    cmp_cond_i,
  input  logic             rd_vld_i,
  input  logic [IW-1:0]    rd_idx_i,
  output logic             commit_o,
  output logic             squash_o
);

  logic [NCMP*NPRED-1:0] we_all;
  logic [NCMP*NPRED-1:0] wval_all;
  logic [NPRED-1:0]      pred_q;

  for (genvar p = 0; p < NCMP; p++) begin : g_port
    pred_cmp_decode #(.NPRED(NPRED)) u_dec (
      .vld  (cmp_vld_i[p]),
      .tidx (cmp_tidx_i[p*IW +: IW]),
      .fidx (cmp_fidx_i[p*IW +: IW]),
      .cond (cmp_cond_i[p]),
      .we   (we_all[p*NPRED +: NPRED]),
      .wval (wval_all[p*NPRED +: NPRED])
    );
  end

  pred_bank #(.NPRED(NPRED), .NCMP(NCMP)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .we_all   (we_all),
    .wval_all (wval_all),
    .state    (pred_q)
  );

  pred_rd_port #(.NPRED(NPRED)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_vld (rd_vld_i),
    .rd_idx (rd_idx_i),
    .state  (pred_q),
    .commit (commit_o),
    .squash (squash_o)
  );

endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
  parameter int unsigned NPRED = 64,
  parameter int unsigned NCMP  = 2,
  localparam int unsigned IW = $clog2(NPRED)
) (
  input logic             clk,
  input logic             rst,
  input logic [NCMP-1:0]    cmp_vld_i,
  input logic [NCMP*IW-1:0] cmp_tidx_i,
  input logic [NCMP*IW-1:0] cmp_fidx_i,
  input logic [NCMP-1:0]    cmp_cond_i,
  input logic             rd_vld_i,
  input logic [IW-1:0]    rd_idx_i,
  input logic             commit_o,
  input logic             squash_o,
  input logic [NPRED-1:0] pred_q
);

  logic [IW-1:0] t0;
  logic [IW-1:0] f0;
  assign t0 = cmp_tidx_i[IW-1:0];
  assign f0 = cmp_fidx_i[IW-1:0];

  // R3: index 0 always commits
  p_zero_commits_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_vld_i && rd_idx_i == '0) |=> (commit_o && !squash_o));

  // R5 / R6: outputs never both set
  p_excl_decision_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({commit_o, squash_o}));

  // R7: no request, no decision
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_vld_i |=> (!commit_o && !squash_o));

  // R8: decision reflects the file as it stood before the request's edge
  p_no_bypass_r8: assert property (@(posedge clk) disable iff (rst)
    rd_vld_i |=> (commit_o == $past(pred_q[rd_idx_i])));

  // R4: lone compare on port 0 with distinct nonzero targets
  p_pair_write_r4: assert property (@(posedge clk) disable iff (rst)
    (cmp_vld_i == NCMP'(1) && t0 != f0 && t0 != '0 && f0 != '0)
      |=> (pred_q[$past(t0)] == $past(cmp_cond_i[0]) &&
           pred_q[$past(f0)] == !$past(cmp_cond_i[0])));

endmodule

bind pred_file pred_file_chk #(.NPRED(NPRED), .NCMP(NCMP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmp_vld_i  (cmp_vld_i),
  .cmp_tidx_i (cmp_tidx_i),
  .cmp_fidx_i (cmp_fidx_i),
  .cmp_cond_i (cmp_cond_i),
  .rd_vld_i   (rd_vld_i),
  .rd_idx_i   (rd_idx_i),
  .commit_o   (commit_o),
  .squash_o   (squash_o),
  .pred_q     (pred_q)
);

// File: tb/pred_file_test.sv
module pred_file_test;

  localparam int NP = 64;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    cmp_vld;
  logic [2*IW-1:0] cmp_tidx;
  logic [2*IW-1:0] cmp_fidx;
  logic [1:0]    cmp_cond;
  logic          rd_vld;
  logic [IW-1:0] rd_idx;
  logic          commit;
  logic          squash;

  int n_chk = 0;
  int n_bad = 0;
  logic mdl [NP];

  always #10 clk = ~clk;

  pred_file uut (
    .clk(clk), .rst(rst),
    .cmp_vld_i(cmp_vld), .cmp_tidx_i(cmp_tidx), .cmp_fidx_i(cmp_fidx),
    .cmp_cond_i(cmp_cond), .rd_vld_i(rd_vld), .rd_idx_i(rd_idx),
    .commit_o(commit), .squash_o(squash)
  );

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {commit,squash} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  // apply to the model: second target then first (first wins), port 1 after port 0
  task automatic mdl_cmp(input int p);
    logic [IW-1:0] t;
    logic [IW-1:0] f;
    t = cmp_tidx[p*IW +: IW];
    f = cmp_fidx[p*IW +: IW];
    if (cmp_vld[p]) begin
      if (f != 0) mdl[f] = ~cmp_cond[p];
      if (t != 0) mdl[t] = cmp_cond[p];
    end
  endtask

  task automatic set_port(input int p, input logic v, input int t, input int f, input logic c);
    cmp_vld[p]            = v;
    cmp_tidx[p*IW +: IW]  = IW'(t);
    cmp_fidx[p*IW +: IW]  = IW'(f);
    cmp_cond[p]           = c;
  endtask

  task automatic issue;
    tick;
    mdl_cmp(0);
    mdl_cmp(1);
    cmp_vld = '0;
  endtask

  task automatic rd_chk(input int idx, input string tag);
    logic e;
    e = mdl[idx];
    rd_vld = 1'b1;
    rd_idx = IW'(idx);
    tick;
    rd_vld = 1'b0;
    chk(tag, {commit, squash}, {e, ~e});
  endtask

  task automatic t_reset;
    rst = 1'b1; cmp_vld = '0; cmp_tidx = '0; cmp_fidx = '0; cmp_cond = '0;
    rd_vld = 1'b0; rd_idx = '0;
    for (int i = 0; i < NP; i++) mdl[i] = (i == 0);
    tick; tick;
    rst = 1'b0;
    tick;
    chk("R2 idle after reset", {commit, squash}, 2'b00);
    rd_chk(1, "R2 reg1 cleared");
    rd_chk(63, "R2 reg63 cleared");
  endtask

  task automatic t_sweep;
    // R1 / R4: every register as first and as second target
    for (int i = 1; i < NP; i += 2) begin
      set_port(0, 1'b1, i, (i + 1) % NP, i[1]);
      issue;
    end
    for (int i = 1; i < NP; i++) rd_chk(i, "R1 R4 sweep");
  endtask

  task automatic t_reg0;
    set_port(0, 1'b1, 0, 7, 1'b0);   // first target is 0: must not clear it
    issue;
    rd_chk(0, "R3 reg0 as first target");
    rd_chk(7, "R3 other target still written");
    set_port(0, 1'b1, 9, 0, 1'b1);   // second target is 0 with inverse 0
    issue;
    rd_chk(0, "R3 reg0 as second target");
    rd_chk(9, "R3 first target still written");
  endtask

  task automatic t_decisions;
    set_port(0, 1'b1, 20, 21, 1'b1);
    issue;
    rd_chk(20, "R5 commit on 1");
    rd_chk(21, "R6 squash on 0");
    tick;
    chk("R7 no request", {commit, squash}, 2'b00);
  endtask

  task automatic t_no_bypass;
    logic old;
    old = mdl[30];
    set_port(0, 1'b1, 30, 31, ~old);
    rd_vld = 1'b1; rd_idx = IW'(30);
    tick;
    mdl_cmp(0);
    cmp_vld = '0; rd_vld = 1'b0;
    chk("R8 same-cycle read sees old", {commit, squash}, {old, ~old});
    rd_chk(30, "R8 next read sees new");
  endtask

  task automatic t_same_target;
    set_port(0, 1'b1, 40, 40, 1'b1);
    issue;
    rd_chk(40, "R9 same target cond=1");
    set_port(0, 1'b1, 40, 40, 1'b0);
    issue;
    rd_chk(40, "R9 same target cond=0");
  endtask

  task automatic t_port_clash;
    set_port(0, 1'b1, 45, 46, 1'b1);
    set_port(1, 1'b1, 46, 45, 1'b1);
    issue;
    rd_chk(45, "R10 port1 wins on 45");
    rd_chk(46, "R10 port1 wins on 46");
  endtask

  task automatic t_dual;
    set_port(0, 1'b1, 50, 51, 1'b0);
    set_port(1, 1'b1, 52, 53, 1'b1);
    issue;
    rd_chk(50, "R11 port0 first");
    rd_chk(51, "R11 port0 second");
    rd_chk(52, "R11 port1 first");
    rd_chk(53, "R11 port1 second");
  endtask

  task automatic t_invalid;
    set_port(0, 1'b0, 52, 53, 1'b0);
    set_port(1, 1'b0, 50, 51, 1'b1);
    cmp_vld = '0;
    tick;
    for (int i = 50; i < 54; i++) rd_chk(i, "R12 invalid port ignored");
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_sweep;
    t_reg0;
    t_decisions;
    t_no_bypass;
    t_same_target;
    t_port_clash;
    t_dual;
    t_invalid;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule